// File: doc/BRIEF.md
# Video Line CRC Inserter

This block sits in the transmit path of a 20-bit parallel high-definition video stream. It runs at one word per clock. It treats the word as two independent 10-bit lanes: luma on bits 19:10 and chroma on bits 9:0. Each lane watches its own half for timing reference sequences. Once a start-of-active-video mark appears, the lane runs an 18-bit CRC over every following word of the line. The run ends with the two line-number words that come after the end-of-active-video mark. The lane then writes the result into the two word slots that follow those line-number words.

A single enable input chooses between insertion and transparent pass-through. Every word, inserted or not, leaves the block exactly one clock after it entered, so the stream keeps its alignment.

Top module: `vcrc_inserter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `dout` becomes all zeros and no lane has an accumulation window open.
- R2: Each output word appears on `dout` one clock after the matching `din` word. Lane bits outside the two check-word slots are copied unchanged.
- R3: Lane 1 (bits 19:10, luma) and lane 0 (bits 9:0, chroma) each detect a timing reference on their own 10-bit half. A reference is the run 3FF, 000, 000, then a status word, where status bit 6 = 1 marks the end of active video and 0 marks the start. A reference on one lane has no effect on the other lane.
- R4: A lane's CRC register clears to zero on the status word of a start mark. It then absorbs every later word up to and including the second line-number word, which covers the end-mark words. Each word is absorbed bit 0 first. For each input bit d: f = c[0] xor d, then c = c >> 1, then, if f is 1, c is XORed with 0x23000. This is the generator x^18 + x^5 + x^4 + 1 in bit-reversed form.
- R5: The two words after the second line-number word are replaced. The first becomes {~c[8], c[8:0]} and the second becomes {~c[17], c[17:9]}, where c is the CRC after the second line-number word.
- R6: While `ins_en` is low, `dout` repeats `din` one clock later. Lowering `ins_en` at any point abandons an open window, and no slot of that line is replaced.
- R7: An end mark that arrives with no window open (no start mark since the last insertion) causes no replacement.
- R8: A second start mark inside an open window restarts that lane's CRC from zero.
- R9: Consecutive lines get independent check words; a line's CRC does not depend on earlier lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_en | input | 1 | High: compute and insert check words; low: pass-through |
| din | input | 20 | Incoming video word, luma 19:10, chroma 9:0 |
| dout | output | 20 | Outgoing video word, one clock behind `din` |

## Verification
A lane tracker stuck in the wrong phase shows up as replaced words in the wrong slots, or as slots left untouched. Either appears at `dout` one clock after the slot enters the block. A corrupted CRC register or step function is not visible until the end of that line, when both check words carry the wrong value. A CRC that is not cleared shows up as wrong check words on the second line sent, while the first line still looks right. A tracker that shares state across lanes is exposed by streams where only one lane carries timing references.

// File: rtl/vcrc_pkg.sv
// Package: shared definitions for the video line CRC inserter.
// Assumes: one lane word per clock, timing reference of three fixed words
// followed by a status word.
package vcrc_pkg;

    // Position of a lane within its line framing
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // no window open
        PH_ACC  = 3'd1,   // after start mark, accumulating
        PH_LN0  = 3'd2,   // first line-number word
        PH_LN1  = 3'd3,   // second line-number word
        PH_CK0  = 3'd4,   // first check-word slot
        PH_CK1  = 3'd5    // second check-word slot
    } phase_e;

    // Bit of the status word that separates end mark (1) from start mark (0)
    localparam int unsigned H_FLAG_BIT = 6;

    // Bit-reversed taps of x^18 + x^5 + x^4 + 1
    localparam int unsigned CRC_TAPS_DEFAULT = 32'h0002_3000;

endpackage

// File: rtl/vcrc_trs_track.sv
// Module: per-lane timing reference tracker.
// Finds the 3-word preamble plus status word on one lane, follows the
// line phase and tells the CRC and output stages what to do with the
// current word. Assumes the preamble never occurs inside active data.
module vcrc_trs_track
    import vcrc_pkg::*;
#(
    parameter int unsigned DW    = 10,
    parameter int unsigned H_BIT = H_FLAG_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] word,
    output logic          crc_clr,
    output logic          crc_adv,
    output logic          slot0,
    output logic          slot1
);

    logic [DW-1:0] hist0, hist1, hist2;   // newest .. oldest previous words
    logic          is_status;
    logic          is_start;
    logic          is_end;
    phase_e        phase_q, phase_d;

    // Preamble match: all-ones, zeros, zeros on the three previous words
    assign is_status = (hist2 == {DW{1'b1}}) && (hist1 == '0) && (hist0 == '0);
    assign is_start  = is_status && !word[H_BIT];
    assign is_end    = is_status &&  word[H_BIT];

    // Shift the three-word history used to spot the preamble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist0 <= '0;
            hist1 <= '0;
            hist2 <= '0;
        end else begin
            hist0 <= word;
            hist1 <= hist0;
            hist2 <= hist1;
        end
    end

    // Phase sequencing across one line
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (is_start) phase_d = PH_ACC;
            PH_ACC:  if (is_end)   phase_d = PH_LN0;
            PH_LN0:  phase_d = PH_LN1;
            PH_LN1:  phase_d = PH_CK0;
            PH_CK0:  phase_d = PH_CK1;
            PH_CK1:  phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
        if (!en) phase_d = PH_IDLE;
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Per-word commands for the CRC and output stages
    always_comb begin
        crc_clr = en && is_start && (phase_q == PH_IDLE || phase_q == PH_ACC);
        crc_adv = en && !crc_clr &&
                  (phase_q == PH_ACC || phase_q == PH_LN0 || phase_q == PH_LN1);
        slot0   = en && (phase_q == PH_CK0);
        slot1   = en && (phase_q == PH_CK1);
    end

endmodule

// File: rtl/vcrc_crc_acc.sv
// Module: per-lane CRC accumulator.
// Absorbs one DW-bit word per clock, bit 0 first, using an unrolled copy
// of the serial reflected LFSR. Assumes clr and adv are never high together.
module vcrc_crc_acc #(
    parameter int unsigned DW   = 10,
    parameter int unsigned CW   = 18,
    parameter int unsigned TAPS = 32'h0002_3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [DW-1:0] word,
    output logic [CW-1:0] crc
);

    localparam logic [CW-1:0] TAP_MASK = CW'(TAPS);

    logic [CW-1:0] chain [DW+1];   // state after each absorbed bit
    logic [DW-1:0] fb;             // feedback bit per stage

    assign chain[0] = crc;

    // One serial LFSR step per input bit
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign fb[b]       = chain[b][0] ^ word[b];
        assign chain[b+1]  = (chain[b] >> 1) ^ (fb[b] ? TAP_MASK : '0);
    end

    // CRC register: clear on start mark, advance on counted words
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (adv) crc <= chain[DW];
    end

endmodule

// File: rtl/vcrc_lane.sv
// Module: one lane of the inserter.
// Ties the tracker and the CRC together and registers the lane output,
// replacing the two check-word slots with the formatted CRC halves.
// Assumes the CRC width is twice (DW - 1).
module vcrc_lane
    import vcrc_pkg::*;
#(
    parameter int unsigned DW    = 10,
    parameter int unsigned TAPS  = CRC_TAPS_DEFAULT,
    parameter int unsigned H_BIT = H_FLAG_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] word_out,
    output logic          slot0,
    output logic          slot1,
    output logic          adv
);

    localparam int unsigned HALF = DW - 1;
    localparam int unsigned CW   = 2 * HALF;

    logic          clr;
    logic [CW-1:0] crc;
    logic [DW-1:0] ck0_word, ck1_word;

    vcrc_trs_track #(
        .DW    (DW),
        .H_BIT (H_BIT)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .word    (word_in),
        .crc_clr (clr),
        .crc_adv (adv),
        .slot0   (slot0),
        .slot1   (slot1)
    );

    vcrc_crc_acc #(
        .DW   (DW),
        .CW   (CW),
        .TAPS (TAPS)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (adv),
        .word  (word_in),
        .crc   (crc)
    );

    // Check words: CRC half plus an inverted copy of its top bit
    assign ck0_word = {~crc[HALF-1], crc[HALF-1:0]};
    assign ck1_word = {~crc[CW-1],   crc[CW-1:HALF]};

    // Output register: same one-clock delay for every word
    always_ff @(posedge clk) begin
        if (!rst_n)     word_out <= '0;
        else if (slot0) word_out <= ck0_word;
        else if (slot1) word_out <= ck1_word;
        else            word_out <= word_in;
    end

endmodule

// File: rtl/vcrc_inserter.sv
// Module: video line CRC inserter, top level.
// Splits the parallel word into independent lanes (lane 0 = low bits),
// each with its own framing and CRC, and reassembles the output.
// Assumes one word per clock and ins_en sampled with the word.
module vcrc_inserter
    import vcrc_pkg::*;
#(
    parameter int unsigned LANE_W   = 10,
    parameter int unsigned LANES    = 2,
    parameter int unsigned CRC_TAPS = CRC_TAPS_DEFAULT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ins_en,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout
);

    logic [LANES-1:0] lane_slot0;
    logic [LANES-1:0] lane_slot1;
    logic [LANES-1:0] lane_adv;

    // One lane per LANE_W slice of the word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vcrc_lane #(
            .DW    (LANE_W),
            .TAPS  (CRC_TAPS),
            .H_BIT (H_FLAG_BIT)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ins_en),
            .word_in  (din[g*LANE_W +: LANE_W]),
            .word_out (dout[g*LANE_W +: LANE_W]),
            .slot0    (lane_slot0[g]),
            .slot1    (lane_slot1[g]),
            .adv      (lane_adv[g])
        );
    end

endmodule

// File: rtl/vcrc_inserter_chk.sv
// Module: assertion checker for the inserter, bound to the top level.
// Relates the ports to the per-lane slot and advance strobes.
module vcrc_inserter_chk #(
    parameter int unsigned LANE_W = 10,
    parameter int unsigned LANES  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ins_en,
    input logic [LANES*LANE_W-1:0] din,
    input logic [LANES*LANE_W-1:0] dout,
    input logic [LANES-1:0]        lane_slot0,
    input logic [LANES-1:0]        lane_slot1,
    input logic [LANES-1:0]        lane_adv
);

    // Output is cleared by reset
    assert_reset_clears_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (dout == '0));

    // Disabled words come straight through one clock later
    assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ins_en)) |-> (dout == $past(din)));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // Non-slot lane words are copied with one clock of delay
        assert_copy_outside_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(lane_slot0[g]) && !$past(lane_slot1[g]))
            |-> (dout[g*LANE_W +: LANE_W] == $past(din[g*LANE_W +: LANE_W])));

        // Second slot always follows the first
        assert_slot_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
            lane_slot0[g] |=> lane_slot1[g]);

        // Inserted words carry an inverted copy of bit 8 in bit 9
        assert_ck_guard_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(lane_slot0[g]) || $past(lane_slot1[g])))
            |-> (dout[g*LANE_W + LANE_W-1] != dout[g*LANE_W + LANE_W-2]));

        // The first slot comes right after an absorbed line-number word
        assert_slot_after_accum_R4: assert property (@(posedge clk) disable iff (!rst_n)
            lane_slot0[g] |-> $past(lane_adv[g]));

        // No accumulation and no insertion while disabled
        assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !ins_en |-> (!lane_adv[g] && !lane_slot0[g] && !lane_slot1[g]));

        // A lane is never in two roles at once
        assert_roles_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({lane_adv[g], lane_slot0[g], lane_slot1[g]}));
    end

endmodule

bind vcrc_inserter vcrc_inserter_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (ins_en),
    .din        (din),
    .dout       (dout),
    .lane_slot0 (lane_slot0),
    .lane_slot1 (lane_slot1),
    .lane_adv   (lane_adv)
);

// File: tb/test_vcrc_inserter.sv
// Scoreboard bench: the driver computes each expected output word from the
// requirements and queues it; the monitor compares one clock later.
module test_vcrc_inserter;

    localparam int LW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_en = 1'b0;
    logic [19:0] din = '0;
    logic [19:0] dout;

    typedef struct {
        logic [19:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Reference model state per lane: 0 idle,1 acc,2 ln0,3 ln1,4 ck0,5 ck1
    int          m_ph [2];
    logic [9:0]  m_h  [2][3];
    logic [17:0] m_crc[2];
    logic [9:0]  gen_state = 10'h2A5;

    vcrc_inserter i_vcrc_inserter (
        .clk    (clk),
        .rst_n  (rst_n),
        .ins_en (ins_en),
        .din    (din),
        .dout   (dout)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Serial CRC exactly as R4 states it
    function automatic logic [17:0] crc_word(logic [17:0] c, logic [9:0] d);
        for (int b = 0; b < 10; b++) begin
            logic f;
            f = c[0] ^ d[b];
            c = c >> 1;
            if (f) c = c ^ 18'h23000;
        end
        return c;
    endfunction

    // Expected lane output for one word, then advance the model (R3-R8)
    task automatic model_lane(input int l, input logic [9:0] x, input bit en,
                              output logic [9:0] y);
        bit is_stat;
        is_stat = (m_h[l][2] == 10'h3FF) && (m_h[l][1] == 10'h000) && (m_h[l][0] == 10'h000);
        if (en && m_ph[l] == 4)      y = {~m_crc[l][8],  m_crc[l][8:0]};
        else if (en && m_ph[l] == 5) y = {~m_crc[l][17], m_crc[l][17:9]};
        else                         y = x;
        if (en && is_stat && !x[6] && (m_ph[l] == 0 || m_ph[l] == 1))
            m_crc[l] = '0;
        else if (en && (m_ph[l] == 1 || m_ph[l] == 2 || m_ph[l] == 3))
            m_crc[l] = crc_word(m_crc[l], x);
        if (!en) m_ph[l] = 0;
        else case (m_ph[l])
            0: if (is_stat && !x[6]) m_ph[l] = 1;
            1: if (is_stat &&  x[6]) m_ph[l] = 2;
            5: m_ph[l] = 0;
            default: m_ph[l] = m_ph[l] + 1;
        endcase
        m_h[l][2] = m_h[l][1];
        m_h[l][1] = m_h[l][0];
        m_h[l][0] = x;
    endtask

    // Driver: apply one word at the falling edge and queue its expectation
    task automatic drive(input logic [19:0] w, input bit en, input string tag);
        logic [9:0] y1, y0;
        @(negedge clk);
        din    = w;
        ins_en = en;
        model_lane(1, w[19:10], en, y1);
        model_lane(0, w[9:0],   en, y0);
        q.push_back('{exp: {y1, y0}, tag: tag});
    endtask

    // Pseudo-random active word that never forms a preamble value
    function automatic logic [9:0] next_data();
        gen_state = {gen_state[8:0], gen_state[9] ^ gen_state[6]};
        if (gen_state == 10'h3FF) return 10'h3FE;
        if (gen_state == 10'h000) return 10'h001;
        return gen_state;
    endfunction

    // Reference word k of a mark on the lanes in mask, filler elsewhere
    function automatic logic [19:0] mark_word(int k, bit h, bit [1:0] mask);
        logic [9:0] v, r;
        case (k)
            0: v = 10'h3FF;
            1: v = 10'h000;
            2: v = 10'h000;
            default: v = h ? 10'h274 : 10'h200;   // status bit 6 = H
        endcase
        r = 10'h040;
        return {mask[1] ? v : r, mask[0] ? v : r};
    endfunction

    // One full line; options for disabling, dropping the enable, re-starting
    task automatic send_line(input int n_act, input bit en_line, input int drop_at,
                             input int resav_at, input bit [1:0] mask,
                             input string tag);
        for (int k = 0; k < 4; k++) drive(mark_word(k, 1'b0, mask), en_line, "R2");
        for (int i = 0; i < n_act; i++) begin
            bit e;
            if (i == resav_at)
                for (int k = 0; k < 4; k++) drive(mark_word(k, 1'b0, mask), en_line, "R8");
            e = en_line && !(i == drop_at || i == drop_at + 1);
            drive({next_data(), next_data()}, e, "R2");
        end
        for (int k = 0; k < 4; k++) drive(mark_word(k, 1'b1, mask), en_line, "R2");
        drive({10'h2A4, 10'h2A4}, en_line, "R2");      // LN0
        drive({10'h204, 10'h204}, en_line, "R2");      // LN1
        drive({10'h155, 10'h155}, en_line, tag);       // first slot
        drive({10'h2AA, 10'h2AA}, en_line, tag);       // second slot
        for (int k = 0; k < 3; k++) drive({10'h040, 10'h200}, en_line, "R2");
    endtask

    // Monitor: compare one word per clock, sampled after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_vec++;
                if (dout !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: dout=%h expected=%h", it.tag, dout, it.exp);
                end
            end
        end
    end

    // Stimulus
    initial begin
        for (int l = 0; l < 2; l++) begin
            m_ph[l] = 0; m_crc[l] = '0;
            for (int k = 0; k < 3; k++) m_h[l][k] = '0;
        end
        din = 20'hFFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (dout !== 20'h0) begin
            n_bad++;
            $display("FAIL R1: dout=%h expected=%h", dout, 20'h0);
        end
        rst_n = 1'b1;

        send_line(16, 1'b1, -10, -10, 2'b11, "R5");   // R4/R5 basic insertion
        send_line(23, 1'b1, -10, -10, 2'b11, "R9");   // R9 next line independent
        send_line(5,  1'b1, -10, -10, 2'b11, "R9");   // R9 short line
        send_line(12, 1'b0, -10, -10, 2'b11, "R6");   // R6 disabled line
        send_line(14, 1'b1, 4,   -10, 2'b11, "R6");   // R6 enable dropped mid-line
        send_line(10, 1'b1, -10, 6,   2'b11, "R8");   // R8 restart inside window
        send_line(11, 1'b1, -10, -10, 2'b01, "R3");   // R3 chroma-only marks
        send_line(9,  1'b1, -10, -10, 2'b10, "R3");   // R3 luma-only marks
        // R7: end mark with no window open
        for (int k = 0; k < 4; k++) drive(mark_word(k, 1'b1, 2'b11), 1'b1, "R7");
        drive({10'h2A4, 10'h2A4}, 1'b1, "R7");
        drive({10'h204, 10'h204}, 1'b1, "R7");
        drive({10'h155, 10'h155}, 1'b1, "R7");
        drive({10'h2AA, 10'h2AA}, 1'b1, "R7");
        send_line(20, 1'b1, -10, -10, 2'b11, "R5");   // R5 after idle end mark

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule